// File: doc/BRIEF.md
# Order-Configurable Symmetric FIR Filter

This block is a linear-phase FIR filter whose impulse response is symmetric, so each stored coefficient multiplies the sum of two samples taken from mirrored positions of the delay line. The filter is split into four identical sections of eight taps each. At run time a 4-bit length code picks how many sections take part, which gives 8, 16, 24 or 32 taps. The section that closes the active length ends the accumulation chain with its own partial sum. Every section ahead of it adds the partial sum of the section behind it.

Sixteen signed 16-bit coefficients are held in registers. They can be written one at a time through a simple write port, or replaced together with the length code in one cycle from a 260-bit configuration word. Input samples are 16-bit signed. The result is kept at full precision, 37 bits, with no rounding or saturation. Each accepted sample gives one result a fixed two clock cycles later. Delay positions beyond the active length are held at zero, so a length change never brings back old samples.

Top module: `sym_fir_cascade`

## Requirements
- R1: After reset, res_valid and res_data are 0, all coefficients are 0, the length code is 0001 (8 taps) and every delay position holds 0.
- R2: A sample accepted with smp_valid high at clock edge t produces res_valid high for exactly one cycle after edge t+2. Cycles without smp_valid produce no result.
- R3: For length N, with x[n-k] the sample k places back (k = 0 is the newest), the result is the sum over k = 0..N/2-1 of h[k]*(x[n-k] + x[n-N+1+k]). It is exact in 37-bit two's complement.
- R4: Length codes 0001, 0011, 0111 and 1111 select 8, 16, 24 and 32 taps.
- R5: Any other code gives 8 times the count of consecutive ones starting at bit 0, with a minimum of 8. For example 0101 and 0110 give 8, and 1011 gives 16.
- R6: A write with reg_we high and reg_addr in 0..15 sets h[reg_addr] to reg_wdata. Results computed at later edges use the new value.
- R7: A write to reg_addr 16 sets the length code from reg_wdata[3:0]. Writes to addresses 17..31 change neither the coefficients nor the length.
- R8: When chrom_load is high, the length code becomes chrom_word[3:0] and h[i] becomes chrom_word[4+16i+15 : 4+16i]. This takes priority over a register write in the same cycle.
- R9: At every clock edge, delay positions at or beyond the current length N are set to 0. After the length grows, positions older than the previous length therefore contribute nothing.
- R10: res_data keeps its value in every cycle in which res_valid is low.
- R11: The delay line advances only on cycles with smp_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 16 | Signed input sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | 0..15 coefficient, 16 length code |
| reg_wdata | input | 16 | Write data |
| chrom_load | input | 1 | Load length code and all coefficients from chrom_word |
| chrom_word | input | 260 | Length code in bits 3:0, coefficient i in bits 4+16i upward |
| res_valid | output | 1 | Result strobe |
| res_data | output | 37 | Signed full-precision result |

## Verification
The first test is an impulse through an 8-tap setup with distinct coefficients, which shows the mirrored pairing and the coefficient order. A table of mixed-sign samples, including full-scale extremes, then runs across every valid length code and several non-thermometer codes. Each output tells apart the right fold point from a wrong one. Back-to-back streaming separates the fixed latency from any dependence on gaps between samples. A burst of most-negative values through all 32 taps exercises the widest result. A shrink followed by a grow shows whether the cleared positions really stay at zero. Writes to unused addresses, and a register write in the same cycle as a configuration load, tell apart the correct decoding and priority from a wrong one.

// File: rtl/sfc_pkg.sv
// Shared default widths and structure sizes for the order-configurable
// symmetric FIR. Assumes every section holds the same number of coefficients.
package sfc_pkg;
    localparam int SAMP_W        = 16;
    localparam int COEF_W        = 16;
    localparam int SECTIONS      = 4;
    localparam int PAIRS_PER_SEC = 4;
endpackage

// File: rtl/sfc_len_decode.sv
// Turns the length code into an active section count: the run of ones from
// bit 0, with a minimum of one section. Assumes SECTIONS >= 1.
module sfc_len_decode #(
    parameter int SECTIONS = 4,
    parameter int CNT_W    = 3
) (
    input  logic [SECTIONS-1:0] code,
    output logic [CNT_W-1:0]    n_act
);
    // count the ones from bit 0 and stop at the first zero
    always_comb begin
        logic run;
        run   = 1'b1;
        n_act = '0;
        for (int i = 0; i < SECTIONS; i++) begin
            if (run && code[i]) n_act = n_act + CNT_W'(1);
            else                run   = 1'b0;
        end
        if (n_act == '0) n_act = CNT_W'(1);
    end
endmodule

// File: rtl/sfc_delay_line.sv
// Sample delay line. It shifts on shift_en, and positions at or beyond the
// active length are forced to zero at every edge. Assumes NTAP = SECTIONS*SEC_TAPS.
module sfc_delay_line #(
    parameter int W        = 16,
    parameter int NTAP     = 32,
    parameter int SEC_TAPS = 8,
    parameter int CNT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic signed [W-1:0] din,
    input  logic [CNT_W-1:0]    n_act,
    output logic signed [W-1:0] taps [NTAP]
);
    int lim;

    // active length in taps
    always_comb lim = int'(n_act) * SEC_TAPS;

    for (genvar i = 0; i < NTAP; i++) begin : g_pos
        if (i == 0) begin : g_head
            // first position takes the new sample
            always_ff @(posedge clk) begin
                if (!rst_n)        taps[i] <= '0;
                else if (i >= lim) taps[i] <= '0;
                else if (shift_en) taps[i] <= din;
            end
        end else begin : g_body
            // later positions take their neighbour, or clear when unused
            always_ff @(posedge clk) begin
                if (!rst_n)        taps[i] <= '0;
                else if (i >= lim) taps[i] <= '0;
                else if (shift_en) taps[i] <= taps[i-1];
            end
        end
    end
endmodule

// File: rtl/sfc_section.sv
// One filter section: for each of its coefficients it adds the sample and
// its mirror partner for the current length, then multiplies and sums.
// Assumes it is only used in the chain while SEC_IDX < n_act.
module sfc_section #(
    parameter int SAMP_W   = 16,
    parameter int COEF_W   = 16,
    parameter int PAIRS    = 4,
    parameter int SEC_IDX  = 0,
    parameter int NTAP     = 32,
    parameter int CNT_W    = 3,
    localparam int SEC_TAPS = 2 * PAIRS,
    localparam int PRE_W    = SAMP_W + 1,
    localparam int PROD_W   = PRE_W + COEF_W,
    localparam int SUM_W    = PROD_W + $clog2(PAIRS),
    localparam int IDX_W    = $clog2(NTAP)
) (
    input  logic signed [SAMP_W-1:0] taps  [NTAP],
    input  logic signed [COEF_W-1:0] coefs [PAIRS],
    input  logic [CNT_W-1:0]         n_act,
    output logic signed [SUM_W-1:0]  psum
);
    // pre-add the mirrored pair, multiply and sum across the section
    always_comb begin
        psum = '0;
        for (int j = 0; j < PAIRS; j++) begin
            int k;
            int p;
            logic signed [PRE_W-1:0]  pre;
            logic signed [PROD_W-1:0] prod;
            k = SEC_IDX * PAIRS + j;
            p = int'(n_act) * SEC_TAPS - 1 - k;
            if (p < 0) p = 0;
            pre  = PRE_W'(taps[k]) + PRE_W'(taps[IDX_W'(p)]);
            prod = PROD_W'(pre) * PROD_W'(coefs[j]);
            psum = psum + SUM_W'(prod);
        end
    end
endmodule

// File: rtl/sym_fir_cascade.sv
// Top of the order-configurable symmetric FIR. It holds the coefficient and
// length registers and the sections, chains the sections up to the last
// active one, and registers the result two cycles after each sample.
module sym_fir_cascade
    import sfc_pkg::*;
#(
    parameter int SAMP_W   = sfc_pkg::SAMP_W,
    parameter int COEF_W   = sfc_pkg::COEF_W,
    parameter int SECTIONS = sfc_pkg::SECTIONS,
    parameter int PAIRS    = sfc_pkg::PAIRS_PER_SEC,
    localparam int NCOEF   = SECTIONS * PAIRS,
    localparam int NTAP    = 2 * NCOEF,
    localparam int SEC_TAPS = 2 * PAIRS,
    localparam int CNT_W   = $clog2(SECTIONS + 1),
    localparam int SUM_W   = SAMP_W + 1 + COEF_W + $clog2(PAIRS),
    localparam int ACC_W   = SAMP_W + 1 + COEF_W + $clog2(NCOEF),
    localparam int ADDR_W  = $clog2(NCOEF) + 1,
    localparam int CHROM_W = SECTIONS + NCOEF * COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [SAMP_W-1:0] smp_data,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [COEF_W-1:0]        reg_wdata,
    input  logic                     chrom_load,
    input  logic [CHROM_W-1:0]       chrom_word,
    output logic                     res_valid,
    output logic signed [ACC_W-1:0]  res_data
);
    logic signed [COEF_W-1:0] coef_q [NCOEF];
    logic [SECTIONS-1:0]      order_q;
    logic [CNT_W-1:0]         n_act;
    logic signed [SAMP_W-1:0] taps [NTAP];
    logic signed [SUM_W-1:0]  psum [SECTIONS];
    logic signed [ACC_W-1:0]  chain [SECTIONS];
    logic                     eval_q;

    // configuration registers: a full load wins over a single write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCOEF; i++) coef_q[i] <= '0;
            order_q <= SECTIONS'(1);
        end else if (chrom_load) begin
            order_q <= chrom_word[SECTIONS-1:0];
            for (int i = 0; i < NCOEF; i++)
                coef_q[i] <= chrom_word[SECTIONS + i*COEF_W +: COEF_W];
        end else if (reg_we) begin
            if (!reg_addr[ADDR_W-1])
                coef_q[reg_addr[ADDR_W-2:0]] <= reg_wdata;
            else if (reg_addr == ADDR_W'(NCOEF))
                order_q <= reg_wdata[SECTIONS-1:0];
        end
    end

    sfc_len_decode #(.SECTIONS(SECTIONS), .CNT_W(CNT_W)) u_dec (
        .code  (order_q),
        .n_act (n_act)
    );

    sfc_delay_line #(.W(SAMP_W), .NTAP(NTAP), .SEC_TAPS(SEC_TAPS), .CNT_W(CNT_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (smp_valid),
        .din      (smp_data),
        .n_act    (n_act),
        .taps     (taps)
    );

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        logic signed [COEF_W-1:0] sec_coef [PAIRS];
        for (genvar j = 0; j < PAIRS; j++) begin : g_c
            assign sec_coef[j] = coef_q[s*PAIRS + j];
        end

        sfc_section #(
            .SAMP_W(SAMP_W), .COEF_W(COEF_W), .PAIRS(PAIRS),
            .SEC_IDX(s), .NTAP(NTAP), .CNT_W(CNT_W)
        ) u_sec (
            .taps  (taps),
            .coefs (sec_coef),
            .n_act (n_act),
            .psum  (psum[s])
        );

        if (s == SECTIONS - 1) begin : g_tail
            assign chain[s] = ACC_W'(psum[s]);
        end else begin : g_link
            // the last active section ends the chain, the others pass the sum on
            assign chain[s] = (n_act == CNT_W'(s + 1)) ? ACC_W'(psum[s])
                                                       : ACC_W'(psum[s]) + chain[s+1];
        end
    end

    // result pipeline: the line shifts at the first edge, the result registers at the second
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eval_q    <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            eval_q    <= smp_valid;
            res_valid <= eval_q;
            if (eval_q) res_data <= chain[0];
        end
    end
endmodule

// File: rtl/sym_fir_cascade_chk.sv
// Property checker for sym_fir_cascade, attached by bind. Covers the latency,
// output hold, configuration writes and clearing of unused delay positions.
module sym_fir_cascade_chk #(
    parameter int SAMP_W   = 16,
    parameter int COEF_W   = 16,
    parameter int SECTIONS = 4,
    parameter int NCOEF    = 16,
    parameter int NTAP     = 32,
    parameter int SEC_TAPS = 8,
    parameter int CNT_W    = 3,
    parameter int ACC_W    = 37,
    parameter int ADDR_W   = 5,
    parameter int CHROM_W  = 260
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_valid,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [COEF_W-1:0]        reg_wdata,
    input logic                     chrom_load,
    input logic [CHROM_W-1:0]       chrom_word,
    input logic                     res_valid,
    input logic signed [ACC_W-1:0]  res_data,
    input logic [SECTIONS-1:0]      order_q,
    input logic signed [COEF_W-1:0] coef0,
    input logic [CNT_W-1:0]         n_act,
    input logic signed [SAMP_W-1:0] taps [NTAP]
);
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ##1 res_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ##1 !res_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

    a_r7_order_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !chrom_load && reg_addr == ADDR_W'(NCOEF))
        |=> order_q == $past(reg_wdata[SECTIONS-1:0]));

    a_r7_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !chrom_load && reg_addr > ADDR_W'(NCOEF))
        |=> ($stable(order_q) && $stable(coef0)));

    a_r8_chrom_load: assert property (@(posedge clk) disable iff (!rst_n)
        chrom_load |=> (order_q == $past(chrom_word[SECTIONS-1:0]) &&
                        coef0 == $past(chrom_word[SECTIONS +: COEF_W])));

    for (genvar i = 0; i < NTAP; i++) begin : g_clr
        a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (taps[i] != '0) |-> (i < SEC_TAPS * int'($past(n_act))));
    end
endmodule

bind sym_fir_cascade sym_fir_cascade_chk #(
    .SAMP_W(SAMP_W), .COEF_W(COEF_W), .SECTIONS(SECTIONS), .NCOEF(NCOEF),
    .NTAP(NTAP), .SEC_TAPS(SEC_TAPS), .CNT_W(CNT_W), .ACC_W(ACC_W),
    .ADDR_W(ADDR_W), .CHROM_W(CHROM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .chrom_load (chrom_load),
    .chrom_word (chrom_word),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .order_q    (order_q),
    .coef0      (coef_q[0]),
    .n_act      (n_act),
    .taps       (taps)
);

// File: tb/test_sym_fir_cascade.sv
`timescale 1ns/1ps
module test_sym_fir_cascade;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic               reg_we = 1'b0;
    logic [4:0]         reg_addr = '0;
    logic [15:0]        reg_wdata = '0;
    logic               chrom_load = 1'b0;
    logic [259:0]       chrom_word = '0;
    logic               res_valid;
    logic signed [36:0] res_data;

    int total = 0;
    int bad   = 0;

    // bench reference state
    longint      hist [32];
    longint      hb   [16];
    logic [3:0]  ob;
    longint      expq [64];

    // stimulus table: {length code, sample}
    localparam logic [19:0] STIM [24] = '{
        {4'b0011, 16'h0100}, {4'b0011, 16'hFF00}, {4'b0011, 16'h7FFF},
        {4'b0011, 16'h8000}, {4'b0011, 16'h0001}, {4'b0011, 16'h1234},
        {4'b0111, 16'hFEDC}, {4'b0111, 16'h0050}, {4'b0111, 16'h0000},
        {4'b0111, 16'h4000}, {4'b1111, 16'hC000}, {4'b1111, 16'h0ABC},
        {4'b1111, 16'h7FFF}, {4'b1111, 16'h8001}, {4'b0101, 16'h0011},
        {4'b0101, 16'h2222}, {4'b1011, 16'h0300}, {4'b1011, 16'hF000},
        {4'b0110, 16'h0777}, {4'b0110, 16'h8888}, {4'b1000, 16'h0042},
        {4'b1000, 16'h1111}, {4'b0001, 16'h0005}, {4'b0001, 16'hFFFB}
    };

    sym_fir_cascade i_sym_fir_cascade (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .chrom_load(chrom_load), .chrom_word(chrom_word),
        .res_valid(res_valid), .res_data(res_data)
    );

    always #2 clk = ~clk;

    // length rule from R4 and R5
    function automatic int len_taps(logic [3:0] c);
        int n = 0;
        for (int i = 0; i < 4; i++) begin
            if (c[i] != 1'b1) break;
            n++;
        end
        if (n == 0) n = 1;
        return 8 * n;
    endfunction

    function automatic void zero_beyond();
        for (int k = len_taps(ob); k < 32; k++) hist[k] = 0;
    endfunction

    function automatic void model_shift(longint x);
        for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        zero_beyond();
    endfunction

    function automatic longint ref_y();
        int n = len_taps(ob);
        longint s = 0;
        for (int k = 0; k < n/2; k++) s += hb[k] * (hist[k] + hist[n-1-k]);
        return s;
    endfunction

    task automatic chk(string req, longint got, longint exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic reg_write(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_order(logic [3:0] c);
        reg_write(5'd16, {12'h000, c});
        ob = c;
        repeat (2) @(negedge clk);
        zero_beyond();
    endtask

    task automatic build_chrom(logic [3:0] c);
        chrom_word = '0;
        chrom_word[3:0] = c;
        for (int i = 0; i < 16; i++) chrom_word[4 + 16*i +: 16] = hb[i][15:0];
    endtask

    task automatic send_check(logic signed [15:0] x, string req);
        longint e;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = x;
        model_shift(longint'(x));
        e = ref_y();
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, longint'(res_valid), 1);
        chk(req, longint'(res_data), e);
    endtask

    // back-to-back samples, checked two cycles after each
    task automatic stream(int n, int mode, string req);
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk({req, " valid"}, longint'(res_valid), 1);
                chk(req, longint'(res_data), expq[i-2]);
            end
            if (i < n) begin
                logic signed [15:0] x;
                x = (mode == 1) ? 16'sh8000 : 16'((i * 7919) ^ (i << 11));
                smp_valid = 1'b1; smp_data = x;
                model_shift(longint'(x));
                expq[i] = ref_y();
            end else begin
                smp_valid = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < 32; k++) hist[k] = 0;
        for (int k = 0; k < 16; k++) hb[k] = 0;
        ob = 4'b0001;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the outputs, zero coefficients give zero
        chk("R1 valid after reset", longint'(res_valid), 0);
        chk("R1 data after reset", longint'(res_data), 0);
        send_check(16'sh7FFF, "R1 zero coefficients");

        // R8 and R4: configuration word, 8 taps, impulse response
        for (int k = 0; k < 16; k++) hb[k] = (k % 2 == 1) ? -(k*1000 + 7) : (k*1500 + 300);
        build_chrom(4'b0001);
        @(negedge clk); chrom_load = 1'b1;
        @(negedge clk); chrom_load = 1'b0;
        ob = 4'b0001;
        send_check(16'sd1, "R8 R4 impulse 8 taps");
        for (int i = 0; i < 9; i++) send_check(16'sd0, "R3 impulse tail");

        // table walk over length codes (R3 R4 R5 R9 R7)
        for (int i = 0; i < 24; i++) begin
            if (STIM[i][19:16] != ob) set_order(STIM[i][19:16]);
            send_check(signed'(STIM[i][15:0]), "R3 R4 R5 table");
        end

        // R6: single coefficient write
        set_order(4'b0011);
        reg_write(5'd5, 16'h7ABC);
        hb[5] = 16'sh7ABC;
        send_check(16'sd1, "R6 write");
        for (int i = 0; i < 6; i++) send_check(16'sd0, "R6 impulse after write");

        // R7: unused address leaves length and coefficients alone
        reg_write(5'd20, 16'h000F);
        reg_write(5'd31, 16'h1234);
        for (int i = 0; i < 4; i++) send_check(16'(i*300 - 500), "R7 ignored address");

        // R8: same-cycle load and register write, load wins
        for (int k = 0; k < 16; k++) hb[k] = 16 - k;
        build_chrom(4'b0111);
        @(negedge clk);
        chrom_load = 1'b1; reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = 16'h1111;
        @(negedge clk);
        chrom_load = 1'b0; reg_we = 1'b0;
        ob = 4'b0111;
        repeat (2) @(negedge clk);
        zero_beyond();
        send_check(16'sd1, "R8 priority");
        send_check(16'sd0, "R8 priority tail");

        // R2 R11: back-to-back stream, then idle hold
        stream(10, 0, "R2 stream");
        begin
            longint last;
            @(negedge clk);
            last = longint'(res_data);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R10 idle valid", longint'(res_valid), 0);
                chk("R10 idle hold", longint'(res_data), last);
            end
        end
        send_check(16'sh0444, "R11 no shift while idle");

        // R3: widest result, 32 taps of most-negative values
        for (int k = 0; k < 16; k++) hb[k] = -32768;
        build_chrom(4'b1111);
        @(negedge clk); chrom_load = 1'b1;
        @(negedge clk); chrom_load = 1'b0;
        ob = 4'b1111;
        stream(32, 1, "R3 full scale");
        chk("R3 full scale value", expq[31], 64'sd34359738368);

        // R9: shrink then grow, old samples must stay cleared
        set_order(4'b0001);
        set_order(4'b1111);
        send_check(16'sd0, "R9 cleared after grow");
        send_check(16'sd3, "R9 cleared after grow 2");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule